// File: doc/BRIEF.md
# Repair Address CAM with Self-Repair Flags

This block is a small content-addressable memory that sits beside an SRAM and redirects accesses aimed at defective words. Each entry holds the address of a faulty SRAM word (the tag), a spare data word that stands in for it, an occupancy flag, and two redundant repair flags. The entries only ever hold words with two or more faulty cells, because words with a single faulty cell are left to the ECC. A lookup address is compared against every entry in parallel. The block returns a hit, the index of the matching entry and its spare data.

Defective CAM locations are fenced off by the repair flags. A test controller sets or clears either flag of any entry. If either flag of an entry is 1, that entry never matches and is never chosen to store a new address. A single stuck flag cell therefore cannot bring a bad location back into service. New faulty addresses arrive on an allocate request. A two-state controller accepts the request, checks it for a duplicate, and writes it into the lowest-index free and healthy entry.

A transfer port reads and writes entries by index, so the contents can be copied out to a second CAM and written back after that CAM has been tested. Reset empties every entry but leaves the repair flags as they were, because they record permanent faults.

The controller has two states:
- `CS_IDLE` waits for `alloc_req`. It captures the address and data and moves to `CS_COMMIT`.
- `CS_COMMIT` lasts exactly one cycle. It reports the outcome, writes the entry if one was stored, and always returns to `CS_IDLE`.

Top module: `repair_cam`

## Requirements
- R1: An entry hits a lookup only when all of the following hold: its occupancy flag is 1, both repair flags are 0, and its tag equals `lk_addr`. On a hit, `hit_idx` gives the entry and `hit_data` gives its spare data, both combinationally. With no qualifying entry, `hit` is 0.
- R2: Either repair flag alone at 1 blocks the entry's match. `flag_sel`=0 addresses the first flag and 1 the second. `flag_set` writes 1 and `flag_clr` writes 0; `flag_set` wins if both are high. The change is seen after the next clock edge.
- R3: A stored allocation goes to the lowest-index entry whose occupancy flag is 0 and whose repair flags are both 0. It reports `alloc_status`=00 and gives that entry in `alloc_idx`.
- R4: `full` is 1 exactly when no entry is both empty and unflagged. An allocation with no such entry and no duplicate reports `alloc_status`=10 and changes nothing.
- R5: An allocation whose address already hits a qualifying entry reports `alloc_status`=01. It gives the existing entry in `alloc_idx` and writes nothing. Duplicate detection has priority over the full check.
- R6: When more than one entry hits, `hit_idx` is the lowest matching index and `multi_hit` is 1.
- R7: Reset clears all occupancy flags, so no lookup hits after it. Repair flags keep their values, and allocation after reset still skips flagged entries.
- R8: The transfer read port returns the tag and data of entry `xfer_rd_idx`. `xfer_rd_valid` is 1 when that entry is occupied with both repair flags 0.
- R9: `xfer_wr_en` stores tag and data into `xfer_wr_idx` and marks the entry occupied, but only if both of its repair flags are 0. `xfer_clr` empties the entry. `xfer_wr_en` wins if both are high. Both are ignored while `alloc_busy` is 1.
- R10: `alloc_req` is taken in `CS_IDLE`. In the next cycle (`CS_COMMIT`), `alloc_ack` and `alloc_busy` are 1 for exactly one cycle with the result. Any write takes effect at the end of that cycle. `alloc_req` is ignored in `CS_COMMIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | ADDR_W | Lookup address |
| hit | output | 1 | A qualifying entry matches `lk_addr` |
| hit_idx | output | IDX_W | Lowest matching entry |
| hit_data | output | DATA_W | Spare data of `hit_idx` |
| multi_hit | output | 1 | More than one entry matches |
| alloc_req | input | 1 | Allocate request |
| alloc_addr | input | ADDR_W | Faulty address to store |
| alloc_data | input | DATA_W | Initial spare data |
| alloc_busy | output | 1 | Controller in `CS_COMMIT` |
| alloc_ack | output | 1 | Allocation result valid |
| alloc_status | output | 2 | 00 stored, 01 duplicate, 10 full |
| alloc_idx | output | IDX_W | Entry written, or the existing duplicate |
| full | output | 1 | No empty healthy entry |
| flag_set | input | 1 | Set the selected repair flag |
| flag_clr | input | 1 | Clear the selected repair flag |
| flag_idx | input | IDX_W | Entry for the flag command |
| flag_sel | input | 1 | Which of the two repair flags |
| xfer_rd_idx | input | IDX_W | Transfer read index |
| xfer_rd_tag | output | ADDR_W | Tag of the read entry |
| xfer_rd_data | output | DATA_W | Data of the read entry |
| xfer_rd_valid | output | 1 | Read entry occupied and healthy |
| xfer_wr_en | input | 1 | Transfer write |
| xfer_clr | input | 1 | Empty entry `xfer_wr_idx` |
| xfer_wr_idx | input | IDX_W | Transfer write index |
| xfer_wr_tag | input | ADDR_W | Tag to write |
| xfer_wr_data | input | DATA_W | Data to write |

## Verification
The bench checks every lookup address of a four-entry, four-bit configuration after each operation. This would catch a flag that only one of the two bits honours, or an occupancy check that was dropped, because either fault yields a false hit on a flagged or emptied tag.

It allocates the same address twice in a row. A design that skipped the duplicate check would fill a second entry and raise `multi_hit`.

It writes a duplicate through the transfer port to force a multi-hit. A priority order built the wrong way round would report the higher index.

It flags empty entries below a free one. A free-entry search that ignored the flags would store into a fenced-off location, which then could never hit.

It resets with a flag still set. A design that also reset the flags would allocate into the flagged entry afterwards.

It issues a transfer clear while an allocation is committing. A design without that gate would lose an occupied entry.

// File: rtl/repair_cam_pkg.sv
package repair_cam_pkg;

    typedef enum logic [1:0] {
        ALLOC_STORED = 2'b00,
        ALLOC_DUP    = 2'b01,
        ALLOC_FULL   = 2'b10
    } alloc_res_e;

    typedef enum logic {
        CS_IDLE   = 1'b0,
        CS_COMMIT = 1'b1
    } cam_state_e;

endpackage

// File: rtl/rcam_pick.sv
module rcam_pick #(
    parameter int N    = 16,
    parameter int IW   = 4
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/rcam_store.sv
module rcam_store #(
    parameter int N  = 16,
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int IW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        lk_key,
    input  logic [AW-1:0]        al_key,
    input  logic                 alloc_we,
    input  logic [IW-1:0]        alloc_idx,
    input  logic [DW-1:0]        alloc_data,
    input  logic                 port_we,
    input  logic                 port_clr,
    input  logic [IW-1:0]        port_idx,
    input  logic [AW-1:0]        port_tag,
    input  logic [DW-1:0]        port_data,
    input  logic                 flag_set,
    input  logic                 flag_clr,
    input  logic [IW-1:0]        flag_idx,
    input  logic                 flag_sel,
    output logic [N-1:0][AW-1:0] tag_q,
    output logic [N-1:0][DW-1:0] data_q,
    output logic [N-1:0]         occ_q,
    output logic [N-1:0]         rfa_q,
    output logic [N-1:0]         rfb_q,
    output logic [N-1:0]         lk_match,
    output logic [N-1:0]         al_match,
    output logic [N-1:0]         free_vec
);

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic sel_alloc, sel_port, sel_flag, healthy;

        assign sel_alloc = alloc_we && (alloc_idx == IW'(g));
        assign sel_port  = (port_idx == IW'(g));
        assign sel_flag  = (flag_idx == IW'(g));
        assign healthy   = !rfa_q[g] && !rfb_q[g];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                occ_q[g] <= 1'b0;
            end else if (sel_alloc) begin
                occ_q[g] <= 1'b1;
            end else if (port_we && sel_port && healthy) begin
                occ_q[g] <= 1'b1;
            end else if (port_clr && !port_we && sel_port) begin
                occ_q[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_alloc) begin
                tag_q[g]  <= al_key;
                data_q[g] <= alloc_data;
            end else if (port_we && sel_port && healthy) begin
                tag_q[g]  <= port_tag;
                data_q[g] <= port_data;
            end
        end

        always_ff @(posedge clk) begin
            if (sel_flag && !flag_sel) begin
                if (flag_set) begin
                    rfa_q[g] <= 1'b1;
                end else if (flag_clr) begin
                    rfa_q[g] <= 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (sel_flag && flag_sel) begin
                if (flag_set) begin
                    rfb_q[g] <= 1'b1;
                end else if (flag_clr) begin
                    rfb_q[g] <= 1'b0;
                end
            end
        end

        assign lk_match[g] = occ_q[g] && healthy && (tag_q[g] == lk_key);
        assign al_match[g] = occ_q[g] && healthy && (tag_q[g] == al_key);
        assign free_vec[g] = !occ_q[g] && healthy;
    end

endmodule

// File: rtl/rcam_ctrl.sv
module rcam_ctrl
    import repair_cam_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic [AW-1:0] alloc_addr,
    input  logic [DW-1:0] alloc_data,
    input  logic          dup_any,
    input  logic [IW-1:0] dup_idx,
    input  logic          free_any,
    input  logic [IW-1:0] free_idx,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data,
    output logic          busy,
    output logic          ack,
    output alloc_res_e    status,
    output logic [IW-1:0] res_idx,
    output logic          commit_we
);

    cam_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_IDLE:   if (alloc_req) state_d = CS_COMMIT;
            CS_COMMIT: state_d = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == CS_IDLE && alloc_req) begin
            cap_addr <= alloc_addr;
            cap_data <= alloc_data;
        end
    end

    always_comb begin
        busy      = 1'b0;
        ack       = 1'b0;
        status    = ALLOC_STORED;
        res_idx   = '0;
        commit_we = 1'b0;
        unique case (state_q)
            CS_IDLE: begin
            end
            CS_COMMIT: begin
                busy = 1'b1;
                ack  = 1'b1;
                if (dup_any) begin
                    status  = ALLOC_DUP;
                    res_idx = dup_idx;
                end else if (free_any) begin
                    status    = ALLOC_STORED;
                    res_idx   = free_idx;
                    commit_we = 1'b1;
                end else begin
                    status = ALLOC_FULL;
                end
            end
        endcase
    end

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R10
    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && alloc_req) |=> ack); // R10

endmodule

// File: rtl/repair_cam.sv
module repair_cam
    import repair_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 20,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [DATA_W-1:0] hit_data,
    output logic              multi_hit,
    input  logic              alloc_req,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    output logic              alloc_busy,
    output logic              alloc_ack,
    output logic [1:0]        alloc_status,
    output logic [IDX_W-1:0]  alloc_idx,
    output logic              full,
    input  logic              flag_set,
    input  logic              flag_clr,
    input  logic [IDX_W-1:0]  flag_idx,
    input  logic              flag_sel,
    input  logic [IDX_W-1:0]  xfer_rd_idx,
    output logic [ADDR_W-1:0] xfer_rd_tag,
    output logic [DATA_W-1:0] xfer_rd_data,
    output logic              xfer_rd_valid,
    input  logic              xfer_wr_en,
    input  logic              xfer_clr,
    input  logic [IDX_W-1:0]  xfer_wr_idx,
    input  logic [ADDR_W-1:0] xfer_wr_tag,
    input  logic [DATA_W-1:0] xfer_wr_data
);

    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][DATA_W-1:0] data_q;
    logic [ENTRIES-1:0]             occ_q, rfa_q, rfb_q;
    logic [ENTRIES-1:0]             lk_match, al_match, free_vec;
    logic [ADDR_W-1:0]              cap_addr;
    logic [DATA_W-1:0]              cap_data;
    logic                           dup_any, free_any, commit_we;
    logic [IDX_W-1:0]               dup_idx, free_idx;
    alloc_res_e                     status;

    rcam_store #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_key     (lk_addr),
        .al_key     (cap_addr),
        .alloc_we   (commit_we),
        .alloc_idx  (free_idx),
        .alloc_data (cap_data),
        .port_we    (xfer_wr_en && !alloc_busy),
        .port_clr   (xfer_clr && !alloc_busy),
        .port_idx   (xfer_wr_idx),
        .port_tag   (xfer_wr_tag),
        .port_data  (xfer_wr_data),
        .flag_set   (flag_set),
        .flag_clr   (flag_clr),
        .flag_idx   (flag_idx),
        .flag_sel   (flag_sel),
        .tag_q      (tag_q),
        .data_q     (data_q),
        .occ_q      (occ_q),
        .rfa_q      (rfa_q),
        .rfb_q      (rfb_q),
        .lk_match   (lk_match),
        .al_match   (al_match),
        .free_vec   (free_vec)
    );

    rcam_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick_hit (
        .req (lk_match), .any (hit), .idx (hit_idx)
    );
    rcam_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick_dup (
        .req (al_match), .any (dup_any), .idx (dup_idx)
    );
    rcam_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick_free (
        .req (free_vec), .any (free_any), .idx (free_idx)
    );

    rcam_ctrl #(.AW(ADDR_W), .DW(DATA_W), .IW(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_req  (alloc_req),
        .alloc_addr (alloc_addr),
        .alloc_data (alloc_data),
        .dup_any    (dup_any),
        .dup_idx    (dup_idx),
        .free_any   (free_any),
        .free_idx   (free_idx),
        .cap_addr   (cap_addr),
        .cap_data   (cap_data),
        .busy       (alloc_busy),
        .ack        (alloc_ack),
        .status     (status),
        .res_idx    (alloc_idx),
        .commit_we  (commit_we)
    );

    assign alloc_status  = status;
    assign full          = !free_any;
    assign multi_hit     = ($countones(lk_match) > 1);
    assign hit_data      = data_q[hit_idx];
    assign xfer_rd_tag   = tag_q[xfer_rd_idx];
    assign xfer_rd_data  = data_q[xfer_rd_idx];
    assign xfer_rd_valid = occ_q[xfer_rd_idx] && !rfa_q[xfer_rd_idx]
                           && !rfb_q[xfer_rd_idx];

    AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (occ_q[hit_idx] && !rfa_q[hit_idx] && !rfb_q[hit_idx]
                 && tag_q[hit_idx] == lk_addr)); // R1
    AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit); // R6
    AST_STORE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ack && alloc_status == 2'b00)
        |=> $countones(occ_q) == $past($countones(occ_q)) + 1); // R3
    AST_FULL_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ack && alloc_status == 2'b10) |=> $stable(occ_q)); // R4
    AST_DUP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_ack && alloc_status == 2'b01) |=> $stable(occ_q)); // R5

endmodule

// File: tb/repair_cam_test.sv
module repair_cam_test;

    localparam int PERIOD = 10;
    localparam int N  = 4;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          hit, multi_hit, alloc_busy, alloc_ack, full, xfer_rd_valid;
    logic [IW-1:0] hit_idx, alloc_idx;
    logic [DW-1:0] hit_data, xfer_rd_data;
    logic [1:0]    alloc_status;
    logic          alloc_req = 1'b0;
    logic [AW-1:0] alloc_addr = '0;
    logic [DW-1:0] alloc_data = '0;
    logic          flag_set = 1'b0, flag_clr = 1'b0, flag_sel = 1'b0;
    logic [IW-1:0] flag_idx = '0, xfer_rd_idx = '0, xfer_wr_idx = '0;
    logic [AW-1:0] xfer_rd_tag, xfer_wr_tag = '0;
    logic [DW-1:0] xfer_wr_data = '0;
    logic          xfer_wr_en = 1'b0, xfer_clr = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    logic          m_occ [N];
    logic          m_rfa [N];
    logic          m_rfb [N];
    logic [AW-1:0] m_tag [N];
    logic [DW-1:0] m_dat [N];

    always #(PERIOD / 2) clk = ~clk;

    repair_cam #(.ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .hit(hit),
        .hit_idx(hit_idx), .hit_data(hit_data), .multi_hit(multi_hit),
        .alloc_req(alloc_req), .alloc_addr(alloc_addr),
        .alloc_data(alloc_data), .alloc_busy(alloc_busy),
        .alloc_ack(alloc_ack), .alloc_status(alloc_status),
        .alloc_idx(alloc_idx), .full(full), .flag_set(flag_set),
        .flag_clr(flag_clr), .flag_idx(flag_idx), .flag_sel(flag_sel),
        .xfer_rd_idx(xfer_rd_idx), .xfer_rd_tag(xfer_rd_tag),
        .xfer_rd_data(xfer_rd_data), .xfer_rd_valid(xfer_rd_valid),
        .xfer_wr_en(xfer_wr_en), .xfer_clr(xfer_clr),
        .xfer_wr_idx(xfer_wr_idx), .xfer_wr_tag(xfer_wr_tag),
        .xfer_wr_data(xfer_wr_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_good(input int i);
        return m_occ[i] && !m_rfa[i] && !m_rfb[i];
    endfunction

    function automatic int m_free();
        for (int i = 0; i < N; i++)
            if (!m_occ[i] && !m_rfa[i] && !m_rfb[i]) return i;
        return -1;
    endfunction

    task automatic sweep(input string tag);
        for (int a = 0; a < (1 << AW); a++) begin
            int first = -1;
            int cnt = 0;
            @(negedge clk);
            lk_addr = AW'(a);
            #1;
            for (int i = 0; i < N; i++)
                if (m_good(i) && m_tag[i] == AW'(a)) begin
                    if (first < 0) first = i;
                    cnt++;
                end
            chk({tag, " R1/R2 hit"}, int'(hit), int'(first >= 0));
            if (first >= 0) begin
                chk({tag, " R6 hit_idx"}, int'(hit_idx), first);
                chk({tag, " R1 hit_data"}, int'(hit_data), int'(m_dat[first]));
            end
            chk({tag, " R6 multi_hit"}, int'(multi_hit), int'(cnt > 1));
        end
    endtask

    task automatic chk_full(input string tag);
        #1;
        chk({tag, " R4 full"}, int'(full), int'(m_free() < 0));
    endtask

    task automatic alloc(input int addr, input int data, input string tag);
        int dup = -1;
        int fr;
        int exp_st;
        int exp_ix = 0;
        for (int i = N - 1; i >= 0; i--)
            if (m_good(i) && m_tag[i] == AW'(addr)) dup = i;
        fr = m_free();
        if (dup >= 0) begin exp_st = 1; exp_ix = dup; end
        else if (fr >= 0) begin exp_st = 0; exp_ix = fr; end
        else exp_st = 2;
        @(negedge clk);
        alloc_req = 1'b1; alloc_addr = AW'(addr); alloc_data = DW'(data);
        #1;
        chk({tag, " R10 no ack before edge"}, int'(alloc_ack), 0);
        @(negedge clk);
        alloc_req = 1'b0;
        #1;
        chk({tag, " R10 ack"}, int'(alloc_ack), 1);
        chk({tag, " R10 busy"}, int'(alloc_busy), 1);
        chk({tag, " R3/R4/R5 status"}, int'(alloc_status), exp_st);
        if (exp_st != 2) chk({tag, " R3/R5 idx"}, int'(alloc_idx), exp_ix);
        @(negedge clk);
        if (exp_st == 0) begin
            m_occ[fr] = 1'b1; m_tag[fr] = AW'(addr); m_dat[fr] = DW'(data);
        end
        #1;
        chk({tag, " R10 ack drops"}, int'(alloc_ack), 0);
    endtask

    task automatic flag(input int idx, input int sel, input bit set);
        @(negedge clk);
        flag_idx = IW'(idx); flag_sel = sel[0]; flag_set = set; flag_clr = !set;
        @(negedge clk);
        flag_set = 1'b0; flag_clr = 1'b0;
        if (sel == 0) m_rfa[idx] = set; else m_rfb[idx] = set;
    endtask

    task automatic xwrite(input int idx, input int t, input int d);
        @(negedge clk);
        xfer_wr_en = 1'b1; xfer_wr_idx = IW'(idx);
        xfer_wr_tag = AW'(t); xfer_wr_data = DW'(d);
        @(negedge clk);
        xfer_wr_en = 1'b0;
        if (!m_rfa[idx] && !m_rfb[idx]) begin
            m_occ[idx] = 1'b1; m_tag[idx] = AW'(t); m_dat[idx] = DW'(d);
        end
    endtask

    task automatic xclear(input int idx);
        @(negedge clk);
        xfer_clr = 1'b1; xfer_wr_idx = IW'(idx);
        @(negedge clk);
        xfer_clr = 1'b0;
        m_occ[idx] = 1'b0;
    endtask

    task automatic rd_sweep(input string tag);
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            xfer_rd_idx = IW'(i);
            #1;
            chk({tag, " R8 rd_valid"}, int'(xfer_rd_valid), int'(m_good(i)));
            if (m_good(i)) begin
                chk({tag, " R8 rd_tag"}, int'(xfer_rd_tag), int'(m_tag[i]));
                chk({tag, " R8 rd_data"}, int'(xfer_rd_data), int'(m_dat[i]));
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) m_occ[i] = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_occ[i] = 1'b0; m_rfa[i] = 1'b0; m_rfb[i] = 1'b0;
            m_tag[i] = '0; m_dat[i] = '0;
        end
        do_reset();
        for (int i = 0; i < N; i++) begin
            flag(i, 0, 1'b0);
            flag(i, 1, 1'b0);
        end
        #1;
        chk("R7 reset hit", int'(hit), 0);
        chk("R7 reset busy", int'(alloc_busy), 0);
        chk("R7 reset ack", int'(alloc_ack), 0);
        chk_full("reset");
        sweep("empty R7");

        // R3 fill, R5 back-to-back duplicate, R4 full
        alloc(3, 'hA0, "a3");
        alloc(3, 'hA1, "a3 dup R5");
        alloc(7, 'hB1, "a7");
        alloc(9, 'hC2, "a9");
        alloc(12, 'hD3, "a12");
        chk_full("filled");
        alloc(5, 'hE4, "a5 full R4");
        sweep("filled");

        // R2 each flag alone blocks
        flag(1, 0, 1'b1);
        sweep("flagA e1");
        alloc(7, 'h77, "a7 on flagged R4");
        flag(1, 0, 1'b0);
        flag(1, 1, 1'b1);
        sweep("flagB e1");
        flag(1, 1, 1'b0);
        sweep("cleared e1");
        rd_sweep("rd full");

        // R6 forced duplicate through transfer port, R9
        xclear(2);
        chk_full("after clr R9");
        xwrite(2, 3, 'h55);
        sweep("multi R6");
        rd_sweep("rd multi R9");
        xclear(2);

        // R3 skip flagged entries
        flag(2, 1, 1'b1);
        chk_full("flagged free R4");
        xclear(0);
        flag(0, 0, 1'b1);
        xclear(3);
        alloc(14, 'h9E, "a14 skip R3");
        sweep("skip");

        // R9 write to flagged entry ignored
        xwrite(0, 6, 'h66);
        rd_sweep("rd flagged R9");
        sweep("flagged write R9");

        // R9 transfer clear ignored while busy
        flag(0, 0, 1'b0);
        @(negedge clk);
        alloc_req = 1'b1; alloc_addr = 4'd11; alloc_data = 8'h4B;
        @(negedge clk);
        alloc_req = 1'b0;
        xfer_clr = 1'b1; xfer_wr_idx = 2'd1;
        #1;
        chk("busy R10 status", int'(alloc_status), 0);
        chk("busy R3 idx", int'(alloc_idx), 0);
        @(negedge clk);
        xfer_clr = 1'b0;
        m_occ[0] = 1'b1; m_tag[0] = 4'd11; m_dat[0] = 8'h4B;
        rd_sweep("rd busy R9");
        sweep("busy");

        // R7 reset keeps repair flags (entry 2 flag B still set)
        do_reset();
        sweep("after reset R7");
        chk_full("after reset R7");
        alloc(4, 'h14, "r a4");
        alloc(8, 'h18, "r a8");
        alloc(10, 'h1A, "r a10 skip R7");
        chk_full("after refill R7");
        sweep("refill R7");
        rd_sweep("rd refill");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule